// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Watermarks

This block carries data words from a producer running on one clock to a consumer running on an unrelated clock. The producer pushes a word by raising its increment strobe for one cycle. The word is accepted only while the full flag is low. The consumer sees the oldest stored word on its data output whenever the empty flag is low, and pops it with its own increment strobe. Each clock domain keeps its own position counter. Only the Gray-coded form of that counter crosses to the other domain, through two flip-flop stages.

Besides full and empty, each side raises a watermark flag from a threshold input that can be changed at run time. The write side raises its flag when the free space drops to the threshold or below. The read side raises its flag when the stored count drops to its threshold or below. Each side converts the synchronized Gray value from the far side back to binary and compares counts with a plain binary subtraction. Because of this, the watermark flags are correct from the first write after reset. The flags run on stale copies of the far pointer, so they are conservative: they may be late in clearing, but they are never late in raising.

Top module: `afifo_wm`

## Requirements
- R1: While its reset is high and after it is released, the write side shows full = 0 and almost-full = 0, and the read side shows empty = 1 and almost-empty = 1.
- R2: Words come out on the read side in exactly the order in which they were accepted on the write side, with their values unchanged.
- R3: After DEPTH (default 32) accepted writes with no reads, full is 1 in the write cycle after the last accepted write. A write strobe while full is 1 stores nothing, and the stored contents stay unchanged.
- R4: Once the stored count reaches zero and the write pointer has crossed over, empty is 1. A read strobe while empty is 1 removes nothing.
- R5: Once both pointers have crossed over, almost-full equals (DEPTH − stored count) ≤ write threshold. With a threshold of 4 and a depth of 32, the flag is 0 after 27 stored words and 1 after 28.
- R6: After reset, the first writes into a nearly empty FIFO never raise almost-full when the free space is above the threshold. The flag is 0 in the cycle after each such write.
- R7: Once both pointers have crossed over, almost-empty equals (stored count ≤ read threshold).
- R8: Full = 1 implies almost-full = 1, and empty = 1 implies almost-empty = 1, at every cycle.
- R9: Pointers keep working across many wraps of the address space. Each side's Gray pointer changes by at most one bit per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Write-domain synchronous reset, active high |
| wr_inc | input | 1 | Push strobe, honoured when wr_full is 0 |
| wr_data | input | DATA_W | Word to push |
| wr_afull_thr | input | ADDR_W+1 | Free-space threshold for almost-full |
| wr_full | output | 1 | No free entries (registered) |
| wr_afull | output | 1 | Free space at or below threshold (registered) |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst | input | 1 | Read-domain synchronous reset, active high |
| rd_inc | input | 1 | Pop strobe, honoured when rd_empty is 0 |
| rd_data | output | DATA_W | Oldest stored word, valid while rd_empty is 0 |
| rd_aempty_thr | input | ADDR_W+1 | Stored-count threshold for almost-empty |
| rd_empty | output | 1 | No stored entries (registered) |
| rd_aempty | output | 1 | Stored count at or below threshold (registered) |

## Verification
A corrupted pointer or a wrong Gray-to-binary step shows up at the ports in different ways. A lost or duplicated word appears on rd_data at the next pop. A watermark flag that disagrees with the scoreboard count appears a few cycles after the traffic goes idle, once both synchronizers have settled. A wrap-bit error changes the full or empty decision only after the pointers pass 2×DEPTH. The long random phase drives the pointers through many such wraps and compares every popped word with the model. A flag that fires early on the first writes is visible in the write cycle right after each push.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
  parameter int unsigned CONV_W = 16;

  function automatic logic [CONV_W-1:0] to_gray(input logic [CONV_W-1:0] b);
    return (b >> 1) ^ b;
  endfunction

  function automatic logic [CONV_W-1:0] from_gray(input logic [CONV_W-1:0] g);
    logic [CONV_W-1:0] b;
    b[CONV_W-1] = g[CONV_W-1];
    for (int i = CONV_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/afifo_sync.sv
module afifo_sync #(
  parameter int unsigned W      = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/afifo_mem.sv
module afifo_mem #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ram [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) ram[waddr] <= wdata;
  end

  assign rdata = ram[raddr];
endmodule

// File: rtl/afifo_wr_ctl.sv
module afifo_wr_ctl
  import afifo_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned PTR_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  input  logic [PTR_W-1:0]  thr,
  input  logic [PTR_W-1:0]  far_gray,
  output logic [PTR_W-1:0]  gray,
  output logic [ADDR_W-1:0] addr,
  output logic              we,
  output logic              full,
  output logic              afull
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [PTR_W-1:0] bin_q, bin_nxt, gray_q, gray_nxt, far_bin, occ_nxt;
  logic [CONV_W-1:0] conv;
  logic [PTR_W:0]   level_sum;
  logic             full_q, afull_q, full_nxt, afull_nxt, push;

  assign push     = inc & ~full_q;
  assign bin_nxt  = bin_q + PTR_W'(push);
  assign gray_nxt = (bin_nxt >> 1) ^ bin_nxt;

  assign conv    = from_gray(CONV_W'(far_gray));
  assign far_bin = conv[PTR_W-1:0];
  assign occ_nxt = bin_nxt - far_bin;

  assign full_nxt  = (gray_nxt == {~far_gray[PTR_W-1:PTR_W-2], far_gray[PTR_W-3:0]});
  assign level_sum = {1'b0, occ_nxt} + {1'b0, thr};
  assign afull_nxt = (level_sum >= (PTR_W+1)'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      bin_q   <= '0;
      gray_q  <= '0;
      full_q  <= 1'b0;
      afull_q <= 1'b0;
    end else begin
      bin_q   <= bin_nxt;
      gray_q  <= gray_nxt;
      full_q  <= full_nxt;
      afull_q <= afull_nxt;
    end
  end

  assign gray  = gray_q;
  assign addr  = bin_q[ADDR_W-1:0];
  assign we    = push;
  assign full  = full_q;
  assign afull = afull_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (PTR_W'(bin_q - far_bin) <= PTR_W'(DEPTH))); // R3
  AST_FULL_BLOCKS_PUSH: assert property (@(posedge clk) disable iff (rst)
    (full_q && inc) |=> $stable(bin_q)); // R3
  AST_WGRAY_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    $countones(gray_q ^ $past(gray_q)) <= 1); // R9
  AST_FULL_IMPLIES_AFULL: assert property (@(posedge clk) disable iff (rst)
    full_q |-> afull_q); // R8
endmodule

// File: rtl/afifo_rd_ctl.sv
module afifo_rd_ctl
  import afifo_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned PTR_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  input  logic [PTR_W-1:0]  thr,
  input  logic [PTR_W-1:0]  far_gray,
  output logic [PTR_W-1:0]  gray,
  output logic [ADDR_W-1:0] addr,
  output logic              empty,
  output logic              aempty
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [PTR_W-1:0] bin_q, bin_nxt, gray_q, gray_nxt, far_bin, occ_nxt;
  logic [CONV_W-1:0] conv;
  logic             empty_q, aempty_q, empty_nxt, aempty_nxt, pop;

  assign pop      = inc & ~empty_q;
  assign bin_nxt  = bin_q + PTR_W'(pop);
  assign gray_nxt = (bin_nxt >> 1) ^ bin_nxt;

  assign conv    = from_gray(CONV_W'(far_gray));
  assign far_bin = conv[PTR_W-1:0];
  assign occ_nxt = far_bin - bin_nxt;

  assign empty_nxt  = (gray_nxt == far_gray);
  assign aempty_nxt = (occ_nxt <= thr);

  always_ff @(posedge clk) begin
    if (rst) begin
      bin_q    <= '0;
      gray_q   <= '0;
      empty_q  <= 1'b1;
      aempty_q <= 1'b1;
    end else begin
      bin_q    <= bin_nxt;
      gray_q   <= gray_nxt;
      empty_q  <= empty_nxt;
      aempty_q <= aempty_nxt;
    end
  end

  assign gray   = gray_q;
  assign addr   = bin_q[ADDR_W-1:0];
  assign empty  = empty_q;
  assign aempty = aempty_q;

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (PTR_W'(far_bin - bin_q) <= PTR_W'(DEPTH))); // R4
  AST_EMPTY_BLOCKS_POP: assert property (@(posedge clk) disable iff (rst)
    (empty_q && inc) |=> $stable(bin_q)); // R4
  AST_RGRAY_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    $countones(gray_q ^ $past(gray_q)) <= 1); // R9
  AST_EMPTY_IMPLIES_AEMPTY: assert property (@(posedge clk) disable iff (rst)
    empty_q |-> aempty_q); // R8
endmodule

// File: rtl/afifo_wm.sv
module afifo_wm #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned PTR_W = ADDR_W + 1
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              wr_inc,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PTR_W-1:0]  wr_afull_thr,
  output logic              wr_full,
  output logic              wr_afull,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_inc,
  output logic [DATA_W-1:0] rd_data,
  input  logic [PTR_W-1:0]  rd_aempty_thr,
  output logic              rd_empty,
  output logic              rd_aempty
);
  logic [PTR_W-1:0]  wgray, rgray, wgray_at_rd, rgray_at_wr;
  logic [ADDR_W-1:0] waddr, raddr;
  logic              wen;

  afifo_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
    .clk(wr_clk), .rst(wr_rst), .inc(wr_inc), .thr(wr_afull_thr),
    .far_gray(rgray_at_wr), .gray(wgray), .addr(waddr), .we(wen),
    .full(wr_full), .afull(wr_afull)
  );

  afifo_rd_ctl #(.ADDR_W(ADDR_W)) u_rd (
    .clk(rd_clk), .rst(rd_rst), .inc(rd_inc), .thr(rd_aempty_thr),
    .far_gray(wgray_at_rd), .gray(rgray), .addr(raddr),
    .empty(rd_empty), .aempty(rd_aempty)
  );

  afifo_sync #(.W(PTR_W)) u_w2r (
    .clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_at_rd)
  );

  afifo_sync #(.W(PTR_W)) u_r2w (
    .clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_at_wr)
  );

  afifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wclk(wr_clk), .we(wen), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(rd_data)
  );
endmodule

// File: tb/afifo_wm_test.sv
module afifo_wm_test;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 5;
  localparam int PTR_W  = ADDR_W + 1;
  localparam int DEPTH  = 1 << ADDR_W;

  logic wr_clk = 0, rd_clk = 0;
  logic wr_rst = 1, rd_rst = 1;
  logic wr_inc = 0, rd_inc = 0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [PTR_W-1:0]  wr_afull_thr = 6'd4, rd_aempty_thr = 6'd4;
  logic wr_full, wr_afull, rd_empty, rd_aempty;
  logic [DATA_W-1:0] rd_data;

  int checks = 0, fails = 0;
  logic [DATA_W-1:0] model[$];
  bit done = 0;

  always #2   wr_clk = ~wr_clk;
  always #2.9 rd_clk = ~rd_clk;

  afifo_wm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) uut (.*);

  function automatic bit exp_afull(int cnt, int thr);
    return (DEPTH - cnt) <= thr;
  endfunction
  function automatic bit exp_aempty(int cnt, int thr);
    return cnt <= thr;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(logic [DATA_W-1:0] d);
    @(negedge wr_clk);
    if (!wr_full) model.push_back(d);
    wr_inc  = 1;
    wr_data = d;
    @(negedge wr_clk);
    wr_inc = 0;
  endtask

  task automatic pop(string req);
    @(negedge rd_clk);
    if (!rd_empty) begin
      chk(rd_data == model[0], req, rd_data, model[0]);
      void'(model.pop_front());
    end
    rd_inc = 1;
    @(negedge rd_clk);
    rd_inc = 0;
  endtask

  task automatic settle();
    repeat (10) @(negedge rd_clk);
    repeat (10) @(negedge wr_clk);
  endtask

  task automatic flag_check(string tag);
    chk(wr_afull == exp_afull(model.size(), int'(wr_afull_thr)), {"R5 ", tag},
        wr_afull, exp_afull(model.size(), int'(wr_afull_thr)));
    chk(rd_aempty == exp_aempty(model.size(), int'(rd_aempty_thr)), {"R7 ", tag},
        rd_aempty, exp_aempty(model.size(), int'(rd_aempty_thr)));
    chk(wr_full == (model.size() == DEPTH), {"R3 ", tag}, wr_full, model.size() == DEPTH);
    chk(rd_empty == (model.size() == 0), {"R4 ", tag}, rd_empty, model.size() == 0);
  endtask

  initial begin
    int guard = 0;
    while (!done) begin
      @(posedge wr_clk);
      guard++;
      if (guard > 150000) begin
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  always @(negedge wr_clk) if (!wr_rst && wr_full && !wr_afull)
    chk(0, "R8 full without afull", wr_afull, 1);
  always @(negedge rd_clk) if (!rd_rst && rd_empty && !rd_aempty)
    chk(0, "R8 empty without aempty", rd_aempty, 1);

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge wr_clk);
    // R1: state while reset is held
    chk(wr_full == 0 && wr_afull == 0, "R1 wr flags in reset", {wr_full, wr_afull}, 0);
    chk(rd_empty == 1 && rd_aempty == 1, "R1 rd flags in reset", {rd_empty, rd_aempty}, 3);
    repeat (3) @(negedge rd_clk);
    wr_rst = 0;
    rd_rst = 0;
    settle();
    chk(wr_full == 0 && wr_afull == 0, "R1 wr flags after reset", {wr_full, wr_afull}, 0);
    chk(rd_empty == 1 && rd_aempty == 1, "R1 rd flags after reset", {rd_empty, rd_aempty}, 3);

    // R6: first writes leave almost-full low, checked the cycle after each push
    for (int i = 0; i < 10; i++) begin
      push(DATA_W'(8'h10 + i));
      chk(wr_afull == 0, "R6 afull on early write", wr_afull, 0);
    end
    settle();
    flag_check("after 10 writes");

    // R5: threshold 4 at depth 32, boundary 27 / 28
    for (int i = 10; i < 27; i++) push(DATA_W'(8'h10 + i));
    settle();
    chk(wr_afull == 0, "R5 afull at 27 stored", wr_afull, 0);
    push(8'h2B);
    settle();
    chk(wr_afull == 1, "R5 afull at 28 stored", wr_afull, 1);

    // R3: fill and try overfill
    for (int i = 28; i < DEPTH; i++) push(DATA_W'(8'h10 + i));
    chk(wr_full == 1, "R3 full after DEPTH writes", wr_full, 1);
    push(8'hEE);
    push(8'hEF);
    chk(model.size() == DEPTH, "R3 writes while full dropped", model.size(), DEPTH);
    settle();
    flag_check("full");

    // R2: drain in order
    while (model.size() > 0) pop("R2 directed order");
    settle();
    flag_check("drained");

    // R4: reads while empty remove nothing
    pop("R4 read when empty");
    pop("R4 read when empty");
    push(8'h5A);
    settle();
    chk(rd_empty == 0, "R4 one word visible", rd_empty, 0);
    pop("R4 word after empty reads");

    // R7: almost-empty boundary with threshold 4
    for (int i = 0; i < 5; i++) push(DATA_W'(8'hA0 + i));
    settle();
    chk(rd_aempty == 0, "R7 aempty at 5 stored", rd_aempty, 0);
    pop("R2");
    settle();
    chk(rd_aempty == 1, "R7 aempty at 4 stored", rd_aempty, 1);
    while (model.size() > 0) pop("R2");

    // R9 and R2: random traffic across many pointer wraps
    for (int blk = 0; blk < 8; blk++) begin
      wr_afull_thr  = PTR_W'($urandom_range(0, DEPTH));
      rd_aempty_thr = PTR_W'($urandom_range(0, DEPTH));
      fork
        for (int i = 0; i < 300; i++) begin
          if ($urandom_range(0, 99) < 55 + blk * 3) push(DATA_W'($urandom));
          else @(negedge wr_clk);
        end
        for (int i = 0; i < 220; i++) begin
          if ($urandom_range(0, 99) < 60 - blk * 3) pop("R9 random order");
          else @(negedge rd_clk);
        end
      join
      settle();
      flag_check("random block");
    end
    while (model.size() > 0) pop("R9 final drain");
    settle();
    flag_check("final");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule